// File: doc/BRIEF.md
# Clause-22 Management Master with Single-Word Command Register

This block runs clause-22 management frames to PHYs over a two-wire serial management link (clock MDC, bidirectional data MDIO). A whole transaction lives in one 32-bit register on a simple register bus. Software writes one word that carries a PHY address, a register address, a read/write select, an enable and a busy flag. When busy and enable are both set and the address is legal, the block sends one complete frame. Busy stays set for the length of the frame and then clears.

When a read finishes, the 16 data bits returned by the PHY replace the low half of the same register. Software therefore starts a transaction by writing busy and ends it by polling busy. The data line is split into an output, an output enable and an input, so a pad or tristate buffer at chip level joins them.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the register reads 0, MDC is low and the MDIO output enable is low.
- R2: Register fields: bits 15:0 data, bits 20:16 register address, bits 25:21 PHY address, bit 27 operation (1 read, 0 write), bit 30 enable, bit 31 busy. A write with bit 31 clear is stored as written, reads back unchanged and starts no frame.
- R3: A write frame, as sampled on the MDC rising edges, is 32 ones, then 01, then 01, then the PHY address MSB first, then the register address MSB first, then 10, then the 16 data bits MSB first. That is 64 bits.
- R4: A read frame carries the opcode 10 and leaves the turnaround and data bits to the PHY. The 16 bits sampled in the data phase, MSB first, replace bits 15:0. Bits 30:16 are kept, and bit 31 reads 0.
- R5: One MDC period lasts CLK_DIV system clocks. MDIO changes only together with a falling MDC edge and is sampled on the rising edge.
- R6: During a read frame the output enable is low for both turnaround bits and all 16 data bits. Outside a transaction it is always low.
- R7: After a started write is accepted, busy reads 1 for 64*CLK_DIV cycles and reads 0 after the cycle that follows.
- R8: A register write while busy is set changes nothing, and the running frame goes on unaltered.
- R9: A busy request for PHY address NUM_PHY (5) or higher starts no frame. Busy reads 0 one cycle later, and for a read, bits 15:0 read 0xFFFF.
- R10: A busy request with enable (bit 30) clear starts no frame, and busy reads 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The write strobe is taken at a rising clock edge, and the register shows the new word half a cycle later. The bench therefore checks stored words and rejected requests on the falling edge right after the write. Busy is due to clear after exactly 64*CLK_DIV+1 edges. The bench counts falling edges from the write and checks busy at edge 64*CLK_DIV and again one edge later. Frame contents and the MDC period are taken on MDC rising edges, counted from the number of edges seen before the request, so the 64-bit frame is compared only after the transaction has ended.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W       = 32;
  localparam int DATA_W      = 16;
  localparam int ADDR_W      = 5;
  localparam int FRAME_BITS  = 64;
  localparam int CNT_W       = $clog2(FRAME_BITS);
  localparam int TA_FIRST    = 46;
  localparam int DATA_FIRST  = 48;
  localparam int F_RADDR_LO  = 16;
  localparam int F_PADDR_LO  = 21;
  localparam int F_READ      = 27;
  localparam int F_ENABLE    = 30;
  localparam int F_BUSY      = 31;

  typedef enum logic [1:0] {OP_WRITE = 2'b01, OP_READ = 2'b10} op_code_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic is_rd, input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg, input logic [DATA_W-1:0] wd);
    op_code_t op;
    op = is_rd ? OP_READ : OP_WRITE;
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10,
            is_rd ? {DATA_W{1'b1}} : wd};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          half_done;

  assign half_done = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (half_done) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc     = mdc_q;
  assign rise_ev = run & half_done & ~mdc_q;
  assign fall_ev = run & half_done & mdc_q;

  assert_mdc_low_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  is_read,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rise_ev,
  input  logic                  fall_ev,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  done,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [DATA_W-1:0]     rd_val
);
  logic                  act_q, act_d;
  logic                  done_q, done_d;
  logic                  rd_q, rd_d;
  logic [CNT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]     cap_q, cap_d;
  logic                  cap_en, adv_en, last_bit;

  assign last_bit = (bit_q == CNT_W'(FRAME_BITS - 1));
  assign cap_en   = act_q & rise_ev & rd_q & (bit_q >= CNT_W'(DATA_FIRST));
  assign adv_en   = act_q & fall_ev;

  always_comb begin
    act_d  = act_q;
    done_d = 1'b0;
    rd_d   = rd_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    if (load) begin
      act_d = 1'b1;
      rd_d  = is_read;
      bit_d = '0;
      sh_d  = frame;
      cap_d = '0;
    end else begin
      if (cap_en) cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (adv_en) begin
        if (last_bit) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + CNT_W'(1);
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      cap_q  <= '0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
      rd_q   <= rd_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign active  = act_q;
  assign done    = done_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = act_q & ~(rd_q & (bit_q >= CNT_W'(TA_FIRST)));
  assign rd_val  = cap_q;

  assert_drive_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !fall_ev |=> $stable(mdio_o));
  assert_end_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(fall_ev) && done_q);
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int NUM_PHY = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                  rst_s1, rst_ns;
  logic [REG_W-1:0]      reg_q, reg_d;
  logic                  busy, accept, phy_ok, req, start;
  logic                  active, done, rise_ev, fall_ev;
  logic [DATA_W-1:0]     rd_val;
  logic [FRAME_BITS-1:0] frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ns <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ns <= rst_s1;
    end
  end

  assign busy   = reg_q[F_BUSY];
  assign accept = wr_en & ~busy;
  assign phy_ok = (wr_data[F_PADDR_LO +: ADDR_W] < ADDR_W'(NUM_PHY));
  assign req    = accept & wr_data[F_BUSY];
  assign start  = req & wr_data[F_ENABLE] & phy_ok;
  assign frame  = build_frame(wr_data[F_READ], wr_data[F_PADDR_LO +: ADDR_W],
                              wr_data[F_RADDR_LO +: ADDR_W], wr_data[DATA_W-1:0]);

  always_comb begin
    reg_d = reg_q;
    if (accept) begin
      reg_d         = wr_data;
      reg_d[F_BUSY] = start;
      if (req && !phy_ok && wr_data[F_READ]) reg_d[DATA_W-1:0] = '1;
    end else if (done) begin
      reg_d[F_BUSY] = 1'b0;
      if (reg_q[F_READ]) reg_d[DATA_W-1:0] = rd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) reg_q <= '0;
    else         reg_q <= reg_d;
  end

  assign rd_data = reg_q;

  mdio_clk_div #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_ns), .run(active),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev));

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_ns), .load(start), .is_read(wr_data[F_READ]),
    .frame(frame), .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_i(mdio_i),
    .active(active), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_val(rd_val));

  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    busy && wr_en && !done |=> $stable(rd_data));
  assert_bad_phy_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    req && !phy_ok |=> !active && !rd_data[F_BUSY]);
  assert_no_enable_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    req && !wr_data[F_ENABLE] |=> !active && !rd_data[F_BUSY]);
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    busy && !done |=> busy);
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    start |=> active && busy);
  assert_oe_in_txn_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    mdio_oe |-> busy);
endmodule

// File: tb/sim_mdio_cmd_master.sv
module sim_mdio_cmd_master;
  localparam int DIV = 4;

  logic        clk, rst_n, wr_en;
  logic [31:0] wr_data, rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en, phy_bit, line;
  logic [63:0] cap;
  logic [15:0] resp_val;
  logic        resp_on;
  int          rises, base, cyc, last_rise_cyc, period, oe_bad, checks, fails;
  bit          finished;

  mdio_cmd_master #(.CLK_DIV(DIV), .NUM_PHY(5)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  assign line   = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);
  assign mdio_i = line;

  initial clk = 1'b0;
  always #10 clk = ~clk;
  initial cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  initial begin
    rises = 0; cap = '0; period = 0; last_rise_cyc = 0; oe_bad = 0;
    phy_en = 1'b0; phy_bit = 1'b1;
  end

  always @(posedge mdc) begin
    if (resp_on && (rises - base) >= 46 && mdio_oe) oe_bad = oe_bad + 1;
    cap = {cap[62:0], line};
    period = cyc - last_rise_cyc;
    last_rise_cyc = cyc;
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    int idx;
    idx = rises - base;
    phy_en  = resp_on && idx >= 47 && idx <= 63;
    phy_bit = (idx == 47) ? 1'b0 : ((idx >= 48 && idx <= 63) ? resp_val[63-idx] : 1'b1);
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mkword(input bit bsy, input bit en, input bit rd,
    input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {bsy, en, 2'b00, rd, 1'b0, phy, rg, d};
  endfunction

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
    input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
  endfunction

  task automatic t_reset;
    chk("R1 reg", 64'(rd_data), 64'h0);
    chk("R1 mdc", 64'(mdc), 64'h0);
    chk("R1 oe", 64'(mdio_oe), 64'h0);
  endtask

  task automatic t_store_only;
    logic [31:0] w;
    int r0;
    w = mkword(0, 1, 1, 5'd3, 5'd7, 16'h1234) | 32'h1000_0000;
    r0 = rises;
    do_write(w);
    chk("R2 stored word", 64'(rd_data), 64'(w));
    repeat (20) @(negedge clk);
    chk("R2 no frame", 64'(rises - r0), 64'h0);
  endtask

  task automatic t_write_frame(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] w;
    w = mkword(1, 1, 0, phy, rg, d);
    base = rises; resp_on = 1'b0;
    do_write(w);
    repeat (64*DIV) @(negedge clk);
    chk("R7 busy still set", 64'(rd_data[31]), 64'h1);
    @(negedge clk);
    chk("R7 busy cleared", 64'(rd_data[31]), 64'h0);
    chk("R3 rise count", 64'(rises - base), 64'd64);
    chk("R3 write frame", cap, exp_frame(0, phy, rg, d));
    chk("R5 mdc period", 64'(period), 64'(DIV));
    chk("R2 write word kept", 64'(rd_data), 64'(w & 32'h7FFF_FFFF));
  endtask

  task automatic t_read_frame(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
    logic [31:0] w;
    int ob;
    w = mkword(1, 1, 1, phy, rg, 16'h0);
    base = rises; resp_on = 1'b1; resp_val = v; ob = oe_bad;
    do_write(w);
    repeat (64*DIV + 1) @(negedge clk);
    chk("R4 read result", 64'(rd_data), 64'({1'b0, w[30:16], v}));
    chk("R4 read frame", cap, exp_frame(1, phy, rg, v));
    chk("R6 released in TA/data", 64'(oe_bad - ob), 64'h0);
    chk("R6 idle oe", 64'(mdio_oe), 64'h0);
    resp_on = 1'b0;
  endtask

  task automatic t_busy_ignore;
    logic [31:0] w;
    w = mkword(1, 1, 0, 5'd1, 5'd9, 16'h0F0F);
    base = rises; resp_on = 1'b0;
    do_write(w);
    repeat (10) @(negedge clk);
    wr_en = 1'b1; wr_data = mkword(1, 1, 1, 5'd4, 5'd2, 16'hBEEF);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 reg unchanged", 64'(rd_data), 64'(w));
    while (rd_data[31]) @(negedge clk);
    chk("R8 frame unaltered", cap, exp_frame(0, 5'd1, 5'd9, 16'h0F0F));
    chk("R8 one frame only", 64'(rises - base), 64'd64);
  endtask

  task automatic t_bad_phy;
    logic [31:0] w;
    int r0;
    r0 = rises;
    w = mkword(1, 1, 1, 5'd5, 5'd3, 16'h0000);
    do_write(w);
    chk("R9 read phy5", 64'(rd_data), 64'({1'b0, w[30:16], 16'hFFFF}));
    w = mkword(1, 1, 0, 5'd31, 5'd3, 16'h5555);
    do_write(w);
    chk("R9 write phy31", 64'(rd_data), 64'(w & 32'h7FFF_FFFF));
    repeat (40) @(negedge clk);
    chk("R9 no frame", 64'(rises - r0), 64'h0);
  endtask

  task automatic t_disabled;
    logic [31:0] w;
    int r0;
    r0 = rises;
    w = mkword(1, 0, 0, 5'd2, 5'd1, 16'hAAAA);
    do_write(w);
    chk("R10 busy cleared", 64'(rd_data[31]), 64'h0);
    repeat (40) @(negedge clk);
    chk("R10 no frame", 64'(rises - r0), 64'h0);
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    wr_en = 1'b0; wr_data = '0; resp_on = 1'b0; resp_val = '0; base = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_store_only();
    t_write_frame(5'd2, 5'd5, 16'hA5C3);
    t_write_frame(5'd0, 5'd31, 16'h8001);
    t_read_frame(5'd4, 5'd31, 16'h1234);
    t_read_frame(5'd0, 5'd0, 16'h8001);
    t_busy_ignore();
    t_bad_phy();
    t_disabled();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks = checks + 1; fails = fails + 1;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule